// File: doc/BRIEF.md
# Colour Palette Register Interface

This block holds a 256-entry colour table in which every entry carries an 8-bit red, an 8-bit green and an 8-bit blue value. Software programs the table through a small 16-byte register window of 32-bit words. It first writes a starting entry number to the index word. It then writes colour components to the data word, always red first, then green, then blue. Each completed triple moves the index to the next entry, so a full table can be loaded with one index write and a stream of data writes. Only the top byte of each 32-bit write is used.

A separate lookup port serves a pixel pipeline. It takes an 8-bit entry number and, one clock later, returns the 24-bit colour {red, green, blue} of that entry. Bus writes never stall this port.

The write sequencer is a three-state machine. PH_RED is entered on reset and after any index write. PH_RED goes to PH_GRN on a data write, PH_GRN goes to PH_BLU on a data write, and PH_BLU goes back to PH_RED on a data write while the index advances. An index write from any state goes to PH_RED. All other accesses leave the state unchanged.

Top module: `pal_dac`

## Requirements
- R1: While reset is asserted, the index and the phase clear to 0 (entry 0, red phase). Every entry becomes {00,00,00} except entry 255, which becomes {FF,FF,FF}.
- R2: A write to byte offset 0 loads the index from bits 31:24 of the write data and returns the phase to red.
- R3: Writes to byte offset 4 store bits 31:24 into the red component of the current entry, then the green, then the blue. Exactly one component is written per access.
- R4: The data write that stores blue advances the index by one, wrapping from 255 to 0, and returns the phase to red.
- R5: An index write in the middle of a triple abandons it. Components already written stay in place, and the next data write goes to red of the new entry.
- R6: Writes to any offset other than 0 and 4 (for example 1, 8 or 12) leave the table, the index and the phase unchanged.
- R7: Bits 23:0 of the write data have no effect on the index or on any stored component.
- R8: The read data of the register window is always zero.
- R9: pix_rgb shows {red, green, blue} of the entry presented on pix_idx at the previous clock edge. A table write made at that same edge becomes visible at the next lookup edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Write strobe for one 32-bit access |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, constant zero |
| pix_idx | input | 8 | Lookup entry number |
| pix_rgb | output | 24 | Colour of the looked-up entry: {red, green, blue} |

## Verification
A bus write updates the table on the edge that samples its strobe. A lookup registers on the next edge, so a written colour appears on pix_rgb two edges after the write is presented and one edge after its lookup index is presented. The bench drives inputs on falling edges and samples pix_rgb on the falling edge after the lookup index was applied. For R9 it presents a blue write and a lookup of the same entry together. It then expects the old colour after the first edge and the new colour after the second.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    localparam int NUM_CH = 3;
endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int CH_W     = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int IDX_OFS  = 0,
    parameter int COMP_OFS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [NUM_CH-1:0]   ch_we,
    output logic [IDX_W-1:0]    ch_idx,
    output logic [CH_W-1:0]     ch_val
);
    localparam int IDX_SHIFT = DATA_W - IDX_W;

    phase_e            phase_q, phase_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              idx_wr, comp_wr;

    assign idx_wr  = wr_valid && (wr_addr == ADDR_W'(IDX_OFS));
    assign comp_wr = wr_valid && (wr_addr == ADDR_W'(COMP_OFS));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RED;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    // next state
    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        if (idx_wr) begin
            phase_d = PH_RED;
            idx_d   = wr_data[DATA_W-1 -: IDX_W];
        end else if (comp_wr) begin
            unique case (phase_q)
                PH_RED: phase_d = PH_GRN;
                PH_GRN: phase_d = PH_BLU;
                PH_BLU: begin
                    phase_d = PH_RED;
                    idx_d   = idx_q + 1'b1;
                end
                default: phase_d = PH_RED;
            endcase
        end
    end

    // outputs
    always_comb begin
        ch_we  = '0;
        ch_idx = idx_q;
        ch_val = wr_data[DATA_W-1 -: CH_W];
        if (comp_wr) begin
            unique case (phase_q)
                PH_RED:  ch_we = 3'b100;
                PH_GRN:  ch_we = 3'b010;
                PH_BLU:  ch_we = 3'b001;
                default: ch_we = '0;
            endcase
        end
    end

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (phase_q == PH_RED) &&
                   (idx_q == IDX_W'($past(wr_data) >> IDX_SHIFT)));

    // R4
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_wr && phase_q == PH_BLU) |=>
            (idx_q == IDX_W'($past(idx_q) + 1'b1)) && (phase_q == PH_RED));

    // R6
    ignored_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_wr && !comp_wr) |=> $stable(idx_q) && $stable(phase_q));

    // R3
    one_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_we) && (comp_wr == (ch_we != '0)));
endmodule

// File: rtl/pal_bank.sv
module pal_bank #(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CH_W-1:0]   wr_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CH_W-1:0]   rd_val
);
    localparam int DEPTH = 1 << IDX_W;

    logic [CH_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i == DEPTH - 1) ? {CH_W{1'b1}} : '0;
            end
        end else if (we) begin
            mem[wr_idx] <= wr_val;
        end
    end

    assign rd_val = mem[rd_idx];
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup
    import pal_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH*CH_W-1:0] rgb_in,
    output logic [NUM_CH*CH_W-1:0] rgb_out
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_out <= '0;
        end else begin
            rgb_out <= rgb_in;
        end
    end
endmodule

// File: rtl/pal_dac.sv
module pal_dac
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int CH_W   = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [IDX_W-1:0]        pix_idx,
    output logic [NUM_CH*CH_W-1:0]  pix_rgb
);
    localparam int RGB_W = NUM_CH * CH_W;

    logic [NUM_CH-1:0] ch_we;
    logic [IDX_W-1:0]  ch_idx;
    logic [CH_W-1:0]   ch_val;
    logic [RGB_W-1:0]  rgb_now;

    assign bus_rdata = '0;

    pal_seq #(
        .IDX_W (IDX_W),
        .CH_W  (CH_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_valid(bus_valid),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .ch_we   (ch_we),
        .ch_idx  (ch_idx),
        .ch_val  (ch_val)
    );

    // channel 2 = red (top byte), 1 = green, 0 = blue
    for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
        pal_bank #(
            .IDX_W(IDX_W),
            .CH_W (CH_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (ch_we[c]),
            .wr_idx(ch_idx),
            .wr_val(ch_val),
            .rd_idx(pix_idx),
            .rd_val(rgb_now[c*CH_W +: CH_W])
        );
    end

    pal_lookup #(
        .CH_W(CH_W)
    ) u_lookup (
        .clk    (clk),
        .rst_n  (rst_n),
        .rgb_in (rgb_now),
        .rgb_out(pix_rgb)
    );
endmodule

// File: tb/pal_dac_tb.sv
module pal_dac_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pal_dac u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pix_idx  (pix_idx),
        .pix_rgb  (pix_rgb)
    );

    // vector: {lookup, req[3:0], addr[3:0], data[31:0], exp[23:0]}
    function automatic logic [64:0] vw(input logic [3:0] a, input logic [31:0] d,
                                       input logic [3:0] r);
        return {1'b0, r, a, d, 24'h0};
    endfunction
    function automatic logic [64:0] vl(input logic [7:0] i, input logic [23:0] e,
                                       input logic [3:0] r);
        return {1'b1, r, 4'h0, 24'h0, i, e};
    endfunction

    localparam int NV = 36;
    localparam logic [64:0] VEC [NV] = '{
        vw(4'h0, 32'h10FFFFFF, 4'd2),   // R2, R7: index 16, low bits set
        vw(4'h4, 32'hAA123456, 4'd3),   // R3 red
        vw(4'h4, 32'hBB00FFFF, 4'd3),   // R3 green
        vw(4'h4, 32'hCC0000A5, 4'd3),   // R3 blue, index -> 17
        vw(4'h4, 32'h11000000, 4'd4),   // R4 lands on 17
        vw(4'h4, 32'h22000000, 4'd4),
        vw(4'h4, 32'h33000000, 4'd4),
        vl(8'd16, 24'hAABBCC, 4'd3),    // R3, R7
        vl(8'd17, 24'h112233, 4'd4),    // R4
        vl(8'd18, 24'h000000, 4'd4),
        vw(4'h0, 32'h05000000, 4'd5),   // R5
        vw(4'h4, 32'h44000000, 4'd5),
        vw(4'h0, 32'h06000000, 4'd5),   // R5 abandon triple
        vw(4'h4, 32'h55000000, 4'd5),
        vw(4'h4, 32'h66000000, 4'd5),
        vw(4'h4, 32'h77000000, 4'd5),
        vl(8'd5, 24'h440000, 4'd5),
        vl(8'd6, 24'h556677, 4'd5),
        vw(4'h8, 32'h99000000, 4'd6),   // R6 ignored offsets
        vw(4'hC, 32'h99000000, 4'd6),
        vw(4'h1, 32'h99000000, 4'd6),
        vw(4'h4, 32'h88000000, 4'd6),   // still red of entry 7
        vw(4'h4, 32'h12000000, 4'd6),
        vw(4'h4, 32'h34000000, 4'd6),
        vl(8'd7, 24'h881234, 4'd6),
        vl(8'h99, 24'h000000, 4'd6),
        vw(4'h0, 32'hFF000000, 4'd4),   // R4 wrap
        vw(4'h4, 32'h01000000, 4'd4),
        vw(4'h4, 32'h02000000, 4'd4),
        vw(4'h4, 32'h03000000, 4'd4),
        vw(4'h4, 32'h0A000000, 4'd4),
        vw(4'h4, 32'h0B000000, 4'd4),
        vw(4'h4, 32'h0C000000, 4'd4),
        vl(8'd255, 24'h010203, 4'd4),
        vl(8'd0, 24'h0A0B0C, 4'd4),
        vl(8'd1, 24'h000000, 4'd4)
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_valid = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic lk(input logic [7:0] i, input logic [23:0] e, input int req);
        pix_idx = i;
        @(negedge clk);
        check({8'h0, pix_rgb}, {8'h0, e}, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset contents
        lk(8'd0,   24'h000000, 1);
        lk(8'd128, 24'h000000, 1);
        lk(8'd254, 24'h000000, 1);
        lk(8'd255, 24'hFFFFFF, 1);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][64])
                lk(VEC[k][31:24], VEC[k][23:0], int'(VEC[k][63:60]));
            else
                wr(VEC[k][59:56], VEC[k][55:24]);
        end

        // R8 read data is zero, also while a write is presented
        check(bus_rdata, 32'h0, 8);
        bus_valid = 1'b1; bus_addr = 4'h4; bus_wdata = 32'hFFFFFFFF;
        #1 check(bus_rdata, 32'h0, 8);
        bus_valid = 1'b0; bus_addr = 4'h0; bus_wdata = '0;
        @(negedge clk);

        // R9 write and lookup at the same edge
        wr(4'h0, 32'h14000000);
        wr(4'h4, 32'h5A000000);
        wr(4'h4, 32'h6B000000);
        pix_idx   = 8'd20;
        bus_valid = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h7C000000;
        @(negedge clk);
        bus_valid = 1'b0;
        check({8'h0, pix_rgb}, 32'h005A6B00, 9);
        @(negedge clk);
        check({8'h0, pix_rgb}, 32'h005A6B7C, 9);

        // R1 reset again clears table, index and phase
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        lk(8'd20,  24'h000000, 1);
        lk(8'd255, 24'hFFFFFF, 1);
        wr(4'h4, 32'hAB000000);
        lk(8'd0,   24'hAB0000, 1);

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end
endmodule